// File: doc/BRIEF.md
# Next-Word Load Prefetch Generator

This block sits between a four-lane load/store unit and the request port of a data cache. Each demand load it accepts goes to the cache unchanged, marked as a demand. On the next cycle the block sends a companion prefetch. The prefetch keeps the warp id, PC, thread mask and destination register of the demand, and it moves each lane's address forward by one 32-bit word. Every request carries its own tag and a prefetch marker.

On the return side, cache responses arrive with the prefetch marker and a hit indication. Responses to prefetches are consumed inside the block. Demand responses pass straight through to the writeback port, carrying the hit flag with them.

To measure how useful prefetching is, the block keeps a small ring of recent prefetch lane-0 addresses. It also keeps saturating counters for:
- prefetches issued;
- prefetch hits;
- prefetch misses;
- prefetches that a later demand load touched.

Top module: `next_word_prefetcher`

## Requirements
- R1: In the demand phase, a cache request mirrors the upstream request with the prefetch marker at 0 and all 16 byte-enable bits set. `up_ready` equals `dc_ready` in this phase.
- R2: Each accepted demand is followed on the next cycle by exactly one prefetch request (`dc_pref`=1) with the same warp id, PC, thread mask and destination register. After the prefetch is accepted, the block returns to the demand phase.
- R3: Prefetch lane i address (bits 32i+31..32i of `dc_addr`) equals the demand's lane i address plus 4, modulo 2^32, with each lane computed on its own.
- R4: While a prefetch is pending, `up_ready` is 0. While `dc_ready` is 0, the prefetch request stays valid and unchanged.
- R5: Tags come from a counter that is 0 after reset. Each accepted cache request takes the current value, then the counter increments. A demand with tag T is therefore followed by a prefetch with tag T+1.
- R6: A response with `rsp_pref`=1 never raises `wb_valid`. A demand response raises `wb_valid` in the same cycle, with its tag, hit flag and data unchanged.
- R7: `cnt_issued` counts accepted prefetch requests.
- R8: `cnt_pf_hit` and `cnt_pf_miss` count prefetch responses with `rsp_hit` set and clear respectively. Demand responses change neither counter.
- R9: When an accepted demand's lane-0 address equals a valid stored prefetch lane-0 address, `cnt_useful` increments once and the matched entry is invalidated. A repeat of the same demand therefore does not count again.
- R10: The table holds the last 8 prefetch lane-0 addresses. The ninth push overwrites the oldest entry.
- R11: All four counters saturate at all ones and never wrap.
- R12: Synchronous reset clears all counters, the tag counter and every table entry, and returns the block to the demand phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream load request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_wid | input | WID_W | Warp id |
| up_pc | input | 32 | Instruction address |
| up_tmask | input | 4 | Thread mask |
| up_addr | input | 128 | Four lane addresses, lane 0 in the low bits |
| up_rd | input | 5 | Destination register |
| dc_valid | output | 1 | Cache request valid |
| dc_ready | input | 1 | Cache accepts request |
| dc_wid | output | WID_W | Warp id |
| dc_pc | output | 32 | Instruction address |
| dc_tmask | output | 4 | Thread mask |
| dc_addr | output | 128 | Lane addresses |
| dc_rd | output | 5 | Destination register |
| dc_byteen | output | 16 | Byte enables |
| dc_tag | output | TAG_W | Request tag |
| dc_pref | output | 1 | 1 for a prefetch request |
| rsp_valid | input | 1 | Cache response valid |
| rsp_tag | input | TAG_W | Response tag |
| rsp_pref | input | 1 | Response belongs to a prefetch |
| rsp_hit | input | 1 | Response was a cache hit |
| rsp_data | input | 128 | Response data |
| wb_valid | output | 1 | Writeback response valid |
| wb_tag | output | TAG_W | Writeback tag |
| wb_hit | output | 1 | Hit flag of the writeback response |
| wb_data | output | 128 | Writeback data |
| cnt_issued | output | CNT_W | Prefetches issued |
| cnt_pf_hit | output | CNT_W | Prefetch responses that hit |
| cnt_pf_miss | output | CNT_W | Prefetch responses that missed |
| cnt_useful | output | CNT_W | Prefetches later matched by a demand |

## Verification
Request fields and the writeback path are combinational. The bench drives them just after a falling edge and reads them 1 ns later, within the same cycle. The prefetch appears in the cycle after the edge that accepts the demand, so the bench checks it at the following falling edge and again in each cycle of a stall. The counters and the table update on the accepting edge, so their values are read at the falling edge after that edge. A usefulness probe is issued only after the table push it depends on has been clocked in.

// File: rtl/npf_pkg.sv
package npf_pkg;
    localparam int LANES      = 4;
    localparam int AW         = 32;
    localparam int WORD_BYTES = 4;
    localparam int BEN_W      = LANES * WORD_BYTES;
    localparam int VEC_W      = LANES * AW;
    localparam int PC_W       = 32;
    localparam int RD_W       = 5;

    typedef logic [VEC_W-1:0] lane_addr_t;

    typedef enum logic {
        ST_DEMAND   = 1'b0,
        ST_PREFETCH = 1'b1
    } issue_st_e;

    // Index of each statistics counter
    typedef enum int {
        CNT_ISSUED = 0,
        CNT_HIT    = 1,
        CNT_MISS   = 2,
        CNT_USEFUL = 3
    } cnt_idx_e;
    localparam int NCNT = 4;

    function automatic lane_addr_t next_word(input lane_addr_t a);
        lane_addr_t r;
        for (int i = 0; i < LANES; i++) begin
            r[i*AW +: AW] = a[i*AW +: AW] + AW'(WORD_BYTES);
        end
        return r;
    endfunction
endpackage

// File: rtl/npf_issue_fsm.sv
module npf_issue_fsm
    import npf_pkg::*;
#(
    parameter int WID_W = 2,
    parameter int TAG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 up_valid,
    output logic                 up_ready,
    input  logic [WID_W-1:0]     up_wid,
    input  logic [PC_W-1:0]      up_pc,
    input  logic [LANES-1:0]     up_tmask,
    input  lane_addr_t           up_addr,
    input  logic [RD_W-1:0]      up_rd,
    output logic                 dc_valid,
    input  logic                 dc_ready,
    output logic [WID_W-1:0]     dc_wid,
    output logic [PC_W-1:0]      dc_pc,
    output logic [LANES-1:0]     dc_tmask,
    output lane_addr_t           dc_addr,
    output logic [RD_W-1:0]      dc_rd,
    output logic [BEN_W-1:0]     dc_byteen,
    output logic [TAG_W-1:0]     dc_tag,
    output logic                 dc_pref,
    output logic                 dem_fire,
    output logic                 pf_fire
);
    issue_st_e            state_q;
    logic [TAG_W-1:0]     tag_q;
    logic [WID_W-1:0]     hold_wid;
    logic [PC_W-1:0]      hold_pc;
    logic [LANES-1:0]     hold_tmask;
    lane_addr_t           hold_addr;
    logic [RD_W-1:0]      hold_rd;
    logic                 fire;

    always_comb begin
        if (state_q == ST_DEMAND) begin
            dc_valid = up_valid;
            dc_wid   = up_wid;
            dc_pc    = up_pc;
            dc_tmask = up_tmask;
            dc_addr  = up_addr;
            dc_rd    = up_rd;
            dc_pref  = 1'b0;
            up_ready = dc_ready;
        end else begin
            dc_valid = 1'b1;
            dc_wid   = hold_wid;
            dc_pc    = hold_pc;
            dc_tmask = hold_tmask;
            dc_addr  = next_word(hold_addr);
            dc_rd    = hold_rd;
            dc_pref  = 1'b1;
            up_ready = 1'b0;
        end
        dc_byteen = '1;
        dc_tag    = tag_q;
    end

    assign fire     = dc_valid && dc_ready;
    assign dem_fire = fire && (state_q == ST_DEMAND);
    assign pf_fire  = fire && (state_q == ST_PREFETCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DEMAND;
            tag_q   <= '0;
        end else begin
            if (fire) begin
                tag_q <= tag_q + 1'b1;
            end
            if (dem_fire) begin
                state_q <= ST_PREFETCH;
            end else if (pf_fire) begin
                state_q <= ST_DEMAND;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (dem_fire) begin
            hold_wid   <= up_wid;
            hold_pc    <= up_pc;
            hold_tmask <= up_tmask;
            hold_addr  <= up_addr;
            hold_rd    <= up_rd;
        end
    end
endmodule

// File: rtl/npf_match_table.sv
module npf_match_table #(
    parameter int DEPTH = 8,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          probe,
    input  logic [AW-1:0] probe_addr,
    output logic          hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] valid_q;
    logic [AW-1:0]    addr_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [DEPTH-1:0] match;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = valid_q[g] && (addr_q[g] == probe_addr);
        end
    endgenerate

    assign hit = probe && (|match);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            wr_ptr  <= '0;
        end else begin
            if (probe) begin
                valid_q <= valid_q & ~match;
            end
            if (push) begin
                valid_q[wr_ptr] <= 1'b1;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
        end
    end
endmodule

// File: rtl/npf_sat_counter.sv
module npf_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/next_word_prefetcher.sv
module next_word_prefetcher
    import npf_pkg::*;
#(
    parameter int WID_W     = 2,
    parameter int TAG_W     = 8,
    parameter int TBL_DEPTH = 8,
    parameter int CNT_W     = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   up_valid,
    output logic                   up_ready,
    input  logic [WID_W-1:0]       up_wid,
    input  logic [PC_W-1:0]        up_pc,
    input  logic [LANES-1:0]       up_tmask,
    input  logic [VEC_W-1:0]       up_addr,
    input  logic [RD_W-1:0]        up_rd,
    output logic                   dc_valid,
    input  logic                   dc_ready,
    output logic [WID_W-1:0]       dc_wid,
    output logic [PC_W-1:0]        dc_pc,
    output logic [LANES-1:0]       dc_tmask,
    output logic [VEC_W-1:0]       dc_addr,
    output logic [RD_W-1:0]        dc_rd,
    output logic [BEN_W-1:0]       dc_byteen,
    output logic [TAG_W-1:0]       dc_tag,
    output logic                   dc_pref,
    input  logic                   rsp_valid,
    input  logic [TAG_W-1:0]       rsp_tag,
    input  logic                   rsp_pref,
    input  logic                   rsp_hit,
    input  logic [VEC_W-1:0]       rsp_data,
    output logic                   wb_valid,
    output logic [TAG_W-1:0]       wb_tag,
    output logic                   wb_hit,
    output logic [VEC_W-1:0]       wb_data,
    output logic [CNT_W-1:0]       cnt_issued,
    output logic [CNT_W-1:0]       cnt_pf_hit,
    output logic [CNT_W-1:0]       cnt_pf_miss,
    output logic [CNT_W-1:0]       cnt_useful
);
    logic             dem_fire;
    logic             pf_fire;
    logic             useful_hit;
    logic [NCNT-1:0]  cnt_inc;
    logic [CNT_W-1:0] cnt_val [NCNT];

    npf_issue_fsm #(.WID_W(WID_W), .TAG_W(TAG_W)) issue_i (
        .clk(clk), .rst(rst),
        .up_valid(up_valid), .up_ready(up_ready), .up_wid(up_wid), .up_pc(up_pc),
        .up_tmask(up_tmask), .up_addr(up_addr), .up_rd(up_rd),
        .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_wid(dc_wid), .dc_pc(dc_pc),
        .dc_tmask(dc_tmask), .dc_addr(dc_addr), .dc_rd(dc_rd), .dc_byteen(dc_byteen),
        .dc_tag(dc_tag), .dc_pref(dc_pref),
        .dem_fire(dem_fire), .pf_fire(pf_fire)
    );

    // Lane 0 of dc_addr is the prefetch address when pf_fire, the demand one when dem_fire
    npf_match_table #(.DEPTH(TBL_DEPTH), .AW(AW)) table_i (
        .clk(clk), .rst(rst),
        .push(pf_fire), .push_addr(dc_addr[AW-1:0]),
        .probe(dem_fire), .probe_addr(dc_addr[AW-1:0]),
        .hit(useful_hit)
    );

    // Response return path
    assign wb_valid = rsp_valid && !rsp_pref;
    assign wb_tag   = rsp_tag;
    assign wb_hit   = rsp_hit;
    assign wb_data  = rsp_data;

    always_comb begin
        cnt_inc             = '0;
        cnt_inc[CNT_ISSUED] = pf_fire;
        cnt_inc[CNT_HIT]    = rsp_valid && rsp_pref && rsp_hit;
        cnt_inc[CNT_MISS]   = rsp_valid && rsp_pref && !rsp_hit;
        cnt_inc[CNT_USEFUL] = useful_hit;
    end

    generate
        for (genvar g = 0; g < NCNT; g++) begin : g_cnt
            npf_sat_counter #(.W(CNT_W)) cnt_i (
                .clk(clk), .rst(rst), .inc(cnt_inc[g]), .cnt(cnt_val[g])
            );
        end
    endgenerate

    assign cnt_issued  = cnt_val[CNT_ISSUED];
    assign cnt_pf_hit  = cnt_val[CNT_HIT];
    assign cnt_pf_miss = cnt_val[CNT_MISS];
    assign cnt_useful  = cnt_val[CNT_USEFUL];
endmodule

// File: rtl/npf_checker.sv
module npf_checker
    import npf_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             up_valid,
    input logic             up_ready,
    input logic [VEC_W-1:0] up_addr,
    input logic             dc_valid,
    input logic             dc_ready,
    input logic             dc_pref,
    input logic [VEC_W-1:0] dc_addr,
    input logic [TAG_W-1:0] dc_tag,
    input logic             rsp_valid,
    input logic             rsp_pref,
    input logic             wb_valid,
    input logic [CNT_W-1:0] cnt_issued,
    input logic [CNT_W-1:0] cnt_useful
);
    // R1
    dem_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (dc_valid && !dc_pref) |-> (dc_addr == up_addr && up_ready == dc_ready && up_valid));

    // R2
    pf_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (dc_valid && dc_ready && !dc_pref) |=> (dc_valid && dc_pref));

    // R3
    pf_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (dc_valid && dc_ready && !dc_pref) |=> (dc_addr == next_word($past(dc_addr))));

    // R4
    pf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dc_valid && dc_pref && !dc_ready) |=> (dc_valid && dc_pref && $stable(dc_addr) && $stable(dc_tag)));

    // R4
    no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        dc_pref |-> !up_ready);

    // R5
    tag_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dc_valid && dc_ready) |=> (dc_tag == $past(dc_tag) + 1'b1));

    // R6
    pf_absorb_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_pref) |-> !wb_valid);

    // R11
    issued_mono_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_issued >= $past(cnt_issued));

    // R11
    useful_mono_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_useful >= $past(cnt_useful));
endmodule

bind next_word_prefetcher npf_checker #(.TAG_W(TAG_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_pref(dc_pref), .dc_addr(dc_addr),
    .dc_tag(dc_tag), .rsp_valid(rsp_valid), .rsp_pref(rsp_pref), .wb_valid(wb_valid),
    .cnt_issued(cnt_issued), .cnt_useful(cnt_useful)
);

// File: tb/next_word_prefetcher_tb.sv
module next_word_prefetcher_tb_top;
    localparam int WID_W = 2;
    localparam int TAG_W = 8;
    localparam int CNT_W = 32;
    localparam int SAT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             up_valid = 0;
    logic [WID_W-1:0] up_wid = 0;
    logic [31:0]      up_pc = 0;
    logic [3:0]       up_tmask = 0;
    logic [127:0]     up_addr = 0;
    logic [4:0]       up_rd = 0;
    logic             dc_ready = 1;
    logic             rsp_valid = 0;
    logic [TAG_W-1:0] rsp_tag = 0;
    logic             rsp_pref = 0;
    logic             rsp_hit = 0;
    logic [127:0]     rsp_data = 0;

    logic             up_ready, dc_valid, dc_pref, wb_valid, wb_hit;
    logic [WID_W-1:0] dc_wid;
    logic [31:0]      dc_pc;
    logic [3:0]       dc_tmask;
    logic [127:0]     dc_addr, wb_data;
    logic [4:0]       dc_rd;
    logic [15:0]      dc_byteen;
    logic [TAG_W-1:0] dc_tag, wb_tag;
    logic [CNT_W-1:0] cnt_issued, cnt_pf_hit, cnt_pf_miss, cnt_useful;

    logic             s_up_ready, s_dc_valid, s_dc_pref, s_wb_valid, s_wb_hit;
    logic [WID_W-1:0] s_dc_wid;
    logic [31:0]      s_dc_pc;
    logic [3:0]       s_dc_tmask;
    logic [127:0]     s_dc_addr, s_wb_data;
    logic [4:0]       s_dc_rd;
    logic [15:0]      s_dc_byteen;
    logic [TAG_W-1:0] s_dc_tag, s_wb_tag;
    logic [SAT_W-1:0] s_issued, s_hit, s_miss, s_useful;

    next_word_prefetcher #(.WID_W(WID_W), .TAG_W(TAG_W), .TBL_DEPTH(8), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready), .up_wid(up_wid),
        .up_pc(up_pc), .up_tmask(up_tmask), .up_addr(up_addr), .up_rd(up_rd),
        .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_wid(dc_wid), .dc_pc(dc_pc),
        .dc_tmask(dc_tmask), .dc_addr(dc_addr), .dc_rd(dc_rd), .dc_byteen(dc_byteen),
        .dc_tag(dc_tag), .dc_pref(dc_pref), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_pref(rsp_pref), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .wb_valid(wb_valid),
        .wb_tag(wb_tag), .wb_hit(wb_hit), .wb_data(wb_data), .cnt_issued(cnt_issued),
        .cnt_pf_hit(cnt_pf_hit), .cnt_pf_miss(cnt_pf_miss), .cnt_useful(cnt_useful)
    );

    // Narrow-counter copy on the same stimulus, for saturation
    next_word_prefetcher #(.WID_W(WID_W), .TAG_W(TAG_W), .TBL_DEPTH(8), .CNT_W(SAT_W)) sat_i (
        .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(s_up_ready), .up_wid(up_wid),
        .up_pc(up_pc), .up_tmask(up_tmask), .up_addr(up_addr), .up_rd(up_rd),
        .dc_valid(s_dc_valid), .dc_ready(dc_ready), .dc_wid(s_dc_wid), .dc_pc(s_dc_pc),
        .dc_tmask(s_dc_tmask), .dc_addr(s_dc_addr), .dc_rd(s_dc_rd), .dc_byteen(s_dc_byteen),
        .dc_tag(s_dc_tag), .dc_pref(s_dc_pref), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_pref(rsp_pref), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .wb_valid(s_wb_valid),
        .wb_tag(s_wb_tag), .wb_hit(s_wb_hit), .wb_data(s_wb_data), .cnt_issued(s_issued),
        .cnt_pf_hit(s_hit), .cnt_pf_miss(s_miss), .cnt_useful(s_useful)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [TAG_W-1:0] exp_tag = 0;

    // Each entry: {expected prefetch lanes, demand lanes}, lane 0 in the low word
    localparam int NVEC = 6;
    localparam logic [255:0] VEC [NVEC] = '{
        {128'h10000010_1000000C_10000008_10000004, 128'h1000000C_10000008_10000004_10000000},
        {128'h80000004_80000000_00000004_00000000, 128'h80000000_7FFFFFFC_00000000_FFFFFFFC},
        {128'h20000C14_20000814_20000414_20000014, 128'h20000C10_20000810_20000410_20000010},
        {128'h00040000_00030000_00020000_00010000, 128'h0003FFFC_0002FFFC_0001FFFC_0000FFFC},
        {128'h30000044_30000044_30000044_30000044, 128'h30000040_30000040_30000040_30000040},
        {128'h40000403_40000303_40000203_40000103, 128'h400003FF_400002FF_400001FF_400000FF}
    };

    task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_load(input logic [127:0] a, input logic [127:0] pf, input int stall);
        logic [1:0] w;
        logic [31:0] pc;
        logic [3:0] tm;
        logic [4:0] rd;
        w = 2'(stall + 1); pc = 32'h80000400 + 32'(stall); tm = 4'b0101; rd = 5'd9;
        @(negedge clk);
        up_valid = 1; up_addr = a; up_wid = w; up_pc = pc; up_tmask = tm; up_rd = rd; dc_ready = 1;
        #1;
        check("R1 dc_valid", 128'(dc_valid), 128'd1);
        check("R1 dc_pref", 128'(dc_pref), 128'd0);
        check("R1 dc_addr", dc_addr, a);
        check("R1 dc_byteen", 128'(dc_byteen), 128'hFFFF);
        check("R1 up_ready", 128'(up_ready), 128'd1);
        check("R5 demand tag", 128'(dc_tag), 128'(exp_tag));
        @(negedge clk);
        up_addr = ~a; up_pc = 32'hDEADBEEF; up_rd = 5'd1;
        dc_ready = (stall == 0);
        #1;
        check("R2 prefetch valid", 128'(dc_valid), 128'd1);
        check("R2 prefetch marker", 128'(dc_pref), 128'd1);
        check("R2 prefetch meta", {dc_wid, dc_pc, dc_tmask, dc_rd}, {w, pc, tm, rd});
        check("R3 prefetch addr", dc_addr, pf);
        check("R4 up_ready held low", 128'(up_ready), 128'd0);
        check("R5 prefetch tag", 128'(dc_tag), 128'(exp_tag + 1'b1));
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            #1;
            check("R4 stall hold addr", dc_addr, pf);
            check("R4 stall hold valid", {dc_valid, dc_pref, up_ready}, {1'b1, 1'b1, 1'b0});
        end
        dc_ready = 1;
        @(negedge clk);
        up_valid = 0;
        #1;
        check("R2 single prefetch", {dc_valid, dc_pref}, 2'b00);
        exp_tag = exp_tag + 2'd2;
    endtask

    task automatic do_rsp(input logic pref, input logic hit, input logic [7:0] tg, input logic [127:0] d);
        @(negedge clk);
        rsp_valid = 1; rsp_pref = pref; rsp_hit = hit; rsp_tag = tg; rsp_data = d;
        #1;
        check("R6 wb_valid", 128'(wb_valid), 128'(!pref));
        if (!pref) check("R6 wb fields", {wb_tag, wb_hit, wb_data}, {tg, hit, d});
        @(negedge clk);
        rsp_valid = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R12 reset state
        check("R12 reset outputs", {dc_valid, up_ready}, 2'b01);
        check("R12 reset counters", {cnt_issued, cnt_pf_hit, cnt_pf_miss, cnt_useful}, 128'd0);

        for (int i = 0; i < NVEC; i++) begin
            do_load(VEC[i][127:0], VEC[i][255:128], i % 3);
        end
        check("R7 issued after table", 128'(cnt_issued), 128'd6);
        check("R9 no spurious match", 128'(cnt_useful), 128'd0);

        // R9 match then invalidate
        do_load({4{32'h10000004}}, {4{32'h10000008}}, 0);
        check("R9 useful on match", 128'(cnt_useful), 128'd1);
        do_load({4{32'h10000004}}, {4{32'h10000008}}, 0);
        check("R9 entry invalidated", 128'(cnt_useful), 128'd1);
        do_load({4{32'h00000000}}, {4{32'h00000004}}, 1);
        check("R9 second match", 128'(cnt_useful), 128'd2);

        // R6, R8 responses
        do_rsp(0, 1, 8'h21, 128'hA5A5_0001);
        do_rsp(0, 0, 8'h22, 128'h5A5A_0002);
        do_rsp(1, 1, 8'h23, 128'h0);
        do_rsp(1, 1, 8'h24, 128'h0);
        do_rsp(1, 0, 8'h25, 128'h0);
        @(negedge clk);
        check("R8 hit count", 128'(cnt_pf_hit), 128'd2);
        check("R8 miss count", 128'(cnt_pf_miss), 128'd1);
        check("R7 issued total", 128'(cnt_issued), 128'd9);
        check("R11 saturated issued", 128'(s_issued), 128'd7);
        check("R11 narrow useful", 128'(s_useful), 128'd2);

        // R12 second reset clears table and counters
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        exp_tag = 0;
        #1;
        check("R12 counters cleared", {cnt_issued, cnt_pf_hit, cnt_pf_miss, cnt_useful}, 128'd0);
        do_load({4{32'h10000008}}, {4{32'h1000000C}}, 0);
        check("R12 table cleared", 128'(cnt_useful), 128'd0);

        // R10 oldest entry overwritten
        do_load({4{32'h50000000}}, {4{32'h50000004}}, 0);
        for (int k = 0; k < 8; k++) begin
            do_load({4{32'h60000000 + 32'(k) * 32'h100}}, {4{32'h60000004 + 32'(k) * 32'h100}}, 0);
        end
        do_load({4{32'h50000004}}, {4{32'h50000008}}, 0);
        check("R10 evicted no match", 128'(cnt_useful), 128'd0);
        do_load({4{32'h60000704}}, {4{32'h60000708}}, 0);
        check("R10 newest still matches", 128'(cnt_useful), 128'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule